// File: doc/BRIEF.md
# PHY Register Handshake Access Engine

This block turns a single request for a 16-bit read or write of a PHY-internal register into the strobe-and-acknowledge sequence that the PHY's control port expects. The requester presents an address, write data and a read/write select, and pulses a start strobe. The engine then owns a 32-bit control word towards the PHY and watches one acknowledge bit in the PHY's 32-bit status word. It raises busy while it works and pulses done when it finishes. On a read it also returns the 16-bit value it captured from the status word.

Every access begins by handing the address to the PHY. A write then hands over the data and fires a write strobe. A read instead fires a read strobe and captures the returned value. Each strobe is held until the acknowledge rises. Each release of a strobe is held until the acknowledge falls.

Every such wait samples the acknowledge at a fixed spacing in clock cycles, and only a limited number of times. A wait that never sees the expected level ends the access with an error flag, and the control word returns to zero.

Top module: `phy_hs_engine`

## Requirements
- R1: The control word carries the address or data payload in bits 15:0, the capture-address strobe in bit 16, the capture-data strobe in bit 17, the write strobe in bit 18 and the read strobe in bit 19. At most one strobe is set at a time, and the word is zero whenever the engine is idle.
- R2: Every access starts with the same three control words. First the address alone is driven for one cycle. Next comes the address with bit 16 set, held until acknowledge (status bit 16) reads 1. Last comes the address alone, held until acknowledge reads 0.
- R3: A write continues with the following words in order: the data alone for one cycle; the data with bit 17 set, held until acknowledge is 1; the data alone, held until acknowledge is 0; bit 18 alone, held until acknowledge is 1; the data alone, held until acknowledge is 0. The control word then returns to zero.
- R4: A read continues with bit 19 alone, held until acknowledge is 1. Status bits 15:0 are captured at the acknowledging sample. The control word is then zero, held until acknowledge is 0. The captured value stays on the read-data output until the next read captures a new one.
- R5: Each acknowledge wait samples the acknowledge first in the first cycle its control word is driven, then every SAMPLE_GAP cycles, for at most MAX_TRIES samples. A match at the last allowed sample still succeeds.
- R6: If no sample of a wait matches, the access ends at once: done pulses with the error flag set and the control word back at zero. The error flag is cleared when the next access is accepted.
- R7: A start pulse while busy is ignored. The running access keeps its latched address, data and direction, and no further access follows it.
- R8: Busy rises in the cycle after an accepted start. Done is a one-cycle pulse, and busy is low in the cycle in which done is high.
- R9: After reset the control word, busy, done, the error flag and the read data are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, accepted only when idle |
| wr_i | input | 1 | 1 = write access, 0 = read access |
| addr_i | input | 16 | PHY register address |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last access timed out on an acknowledge wait |
| rdata_o | output | 16 | Data captured by the last successful read |
| phy_ctrl_o | output | 32 | Control word to the PHY |
| phy_stat_i | input | 32 | Status word from the PHY (bit 16 acknowledge, 15:0 data) |

## Verification
The bench builds the engine with SAMPLE_GAP = 4 and MAX_TRIES = 10, so the last sample of a wait falls 36 cycles after its control word appears. This keeps both sides of the retry boundary cheap to reach. A responder whose acknowledge latency is 36 cycles must still succeed, and one at 37 cycles must time out. An access that is never acknowledged has an exact busy length of 38 cycles, which is checked. Responder modes that never raise or never drop the acknowledge cover the error path on both edges.

// File: rtl/phy_hs_pkg.sv
package phy_hs_pkg;

    localparam int FIELD_W  = 16;
    localparam int CTRL_W   = 32;
    localparam int BIT_CAPA = 16;
    localparam int BIT_CAPD = 17;
    localparam int BIT_WSTB = 18;
    localparam int BIT_RSTB = 19;
    localparam int BIT_ACK  = 16;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADR_SET,
        ST_ADR_CAP,
        ST_ADR_REL,
        ST_DAT_SET,
        ST_DAT_CAP,
        ST_DAT_REL,
        ST_WR_STB,
        ST_WR_REL,
        ST_RD_STB,
        ST_RD_REL
    } step_e;

    typedef enum logic [1:0] {
        WT_NONE,
        WT_HIGH,
        WT_LOW
    } wait_e;

    typedef struct packed {
        logic                is_wr;
        logic [FIELD_W-1:0]  addr;
        logic [FIELD_W-1:0]  data;
    } req_t;

    function automatic wait_e step_wait(input step_e s);
        case (s)
            ST_ADR_CAP, ST_DAT_CAP, ST_WR_STB, ST_RD_STB: return WT_HIGH;
            ST_ADR_REL, ST_DAT_REL, ST_WR_REL, ST_RD_REL: return WT_LOW;
            default:                                      return WT_NONE;
        endcase
    endfunction

    function automatic step_e step_next(input step_e s, input logic is_wr);
        case (s)
            ST_ADR_SET: return ST_ADR_CAP;
            ST_ADR_CAP: return ST_ADR_REL;
            ST_ADR_REL: return is_wr ? ST_DAT_SET : ST_RD_STB;
            ST_DAT_SET: return ST_DAT_CAP;
            ST_DAT_CAP: return ST_DAT_REL;
            ST_DAT_REL: return ST_WR_STB;
            ST_WR_STB:  return ST_WR_REL;
            ST_RD_STB:  return ST_RD_REL;
            default:    return ST_IDLE;
        endcase
    endfunction

    function automatic logic [CTRL_W-1:0] step_word(input step_e s, input req_t r);
        logic [CTRL_W-1:0] w;
        w = '0;
        case (s)
            ST_ADR_SET, ST_ADR_REL: w[FIELD_W-1:0] = r.addr;
            ST_ADR_CAP: begin
                w[FIELD_W-1:0] = r.addr;
                w[BIT_CAPA]    = 1'b1;
            end
            ST_DAT_SET, ST_DAT_REL, ST_WR_REL: w[FIELD_W-1:0] = r.data;
            ST_DAT_CAP: begin
                w[FIELD_W-1:0] = r.data;
                w[BIT_CAPD]    = 1'b1;
            end
            ST_WR_STB: w[BIT_WSTB] = 1'b1;
            ST_RD_STB: w[BIT_RSTB] = 1'b1;
            default:   w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/hs_pacer.sv
module hs_pacer #(
    parameter int SAMPLE_GAP = 4,
    parameter int MAX_TRIES  = 10
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic restart_i,
    input  logic active_i,
    output logic sample_o,
    output logic last_o
);
    localparam int GAP_W = (SAMPLE_GAP > 1) ? $clog2(SAMPLE_GAP) : 1;
    localparam int TRY_W = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
    localparam logic [GAP_W-1:0] GAP_RELOAD = GAP_W'(SAMPLE_GAP - 1);
    localparam logic [TRY_W-1:0] TRY_LAST   = TRY_W'(MAX_TRIES - 1);

    logic [GAP_W-1:0] gap_q;
    logic [TRY_W-1:0] try_q;

    assign sample_o = active_i && (gap_q == '0);
    assign last_o   = (try_q == TRY_LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i || restart_i) begin
            gap_q <= '0;
            try_q <= '0;
        end else if (sample_o) begin
            gap_q <= GAP_RELOAD;
            if (!last_o) begin
                try_q <= try_q + 1'b1;
            end
        end else if (active_i) begin
            gap_q <= gap_q - 1'b1;
        end
    end

endmodule

// File: rtl/hs_sequencer.sv
module hs_sequencer
    import phy_hs_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               start_i,
    input  req_t               req_i,
    input  logic               ack_i,
    input  logic [FIELD_W-1:0] stat_data_i,
    input  logic               sample_i,
    input  logic               last_i,
    output logic               restart_o,
    output logic               waiting_o,
    output step_e              step_o,
    output req_t               req_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               err_o,
    output logic [FIELD_W-1:0] rdata_o
);
    step_e  step_q, step_d;
    req_t   req_q;
    wait_e  kind;
    logic   accept, finish, fail, capture, match;
    logic   done_q, err_q;
    logic [FIELD_W-1:0] rdata_q;

    assign kind      = step_wait(step_q);
    assign waiting_o = (kind != WT_NONE);
    assign accept    = (step_q == ST_IDLE) && start_i;
    assign match     = (kind == WT_HIGH) ? ack_i : !ack_i;

    always_comb begin
        step_d    = step_q;
        restart_o = 1'b0;
        finish    = 1'b0;
        fail      = 1'b0;
        capture   = 1'b0;
        if (kind == WT_NONE) begin
            if (step_q == ST_IDLE) begin
                if (start_i) begin
                    step_d    = ST_ADR_SET;
                    restart_o = 1'b1;
                end
            end else begin
                step_d    = step_next(step_q, req_q.is_wr);
                restart_o = 1'b1;
            end
        end else if (sample_i) begin
            if (match) begin
                step_d    = step_next(step_q, req_q.is_wr);
                restart_o = 1'b1;
                capture   = (step_q == ST_RD_STB);
                finish    = (step_d == ST_IDLE);
            end else if (last_i) begin
                step_d    = ST_IDLE;
                restart_o = 1'b1;
                fail      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            step_q  <= ST_IDLE;
            req_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            step_q <= step_d;
            done_q <= finish || fail;
            if (accept) begin
                req_q <= req_i;
                err_q <= 1'b0;
            end else if (fail) begin
                err_q <= 1'b1;
            end
            if (capture) begin
                rdata_q <= stat_data_i;
            end
        end
    end

    assign step_o  = step_q;
    assign req_o   = req_q;
    assign busy_o  = (step_q != ST_IDLE);
    assign done_o  = done_q;
    assign err_o   = err_q;
    assign rdata_o = rdata_q;

endmodule

// File: rtl/hs_word_mux.sv
module hs_word_mux
    import phy_hs_pkg::*;
(
    input  step_e             step_i,
    input  req_t              req_i,
    output logic [CTRL_W-1:0] word_o
);
    always_comb begin
        word_o = step_word(step_i, req_i);
    end
endmodule

// File: rtl/phy_hs_engine.sv
module phy_hs_engine
    import phy_hs_pkg::*;
#(
    parameter int SAMPLE_GAP = 4,
    parameter int MAX_TRIES  = 10
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        start_i,
    input  logic        wr_i,
    input  logic [15:0] addr_i,
    input  logic [15:0] wdata_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        err_o,
    output logic [15:0] rdata_o,
    output logic [31:0] phy_ctrl_o,
    input  logic [31:0] phy_stat_i
);
    req_t  req_in, req_held;
    step_e step;
    logic  restart, waiting, sample, last;

    assign req_in = '{is_wr: wr_i, addr: addr_i, data: wdata_i};

    hs_pacer #(
        .SAMPLE_GAP(SAMPLE_GAP),
        .MAX_TRIES (MAX_TRIES)
    ) u_pacer (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .restart_i(restart),
        .active_i (waiting),
        .sample_o (sample),
        .last_o   (last)
    );

    hs_sequencer u_seq (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .start_i    (start_i),
        .req_i      (req_in),
        .ack_i      (phy_stat_i[BIT_ACK]),
        .stat_data_i(phy_stat_i[FIELD_W-1:0]),
        .sample_i   (sample),
        .last_i     (last),
        .restart_o  (restart),
        .waiting_o  (waiting),
        .step_o     (step),
        .req_o      (req_held),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .err_o      (err_o),
        .rdata_o    (rdata_o)
    );

    hs_word_mux u_word (
        .step_i(step),
        .req_i (req_held),
        .word_o(phy_ctrl_o)
    );

endmodule

// File: rtl/phy_hs_checker.sv
module phy_hs_checker #(
    parameter int GAP   = 4,
    parameter int TRIES = 10
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic [31:0] ctrl
);
    localparam logic [31:0] HOLD_MAX = 32'((TRIES - 1) * GAP + 1);

    logic [31:0] hold_cnt;
    logic [31:0] ctrl_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt  <= '0;
            ctrl_prev <= '0;
        end else begin
            ctrl_prev <= ctrl;
            if (!busy || ctrl != ctrl_prev) begin
                hold_cnt <= '0;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end

    p_one_strobe_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ctrl[19:16]));

    p_idle_word_zero_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ctrl == 32'h0));

    p_wait_bounded_r5: assert property (@(posedge clk) disable iff (rst)
        busy |-> (hold_cnt <= HOLD_MAX));

    p_fail_clears_word_r6: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (ctrl == 32'h0));

    p_accept_start_r7: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

endmodule

bind phy_hs_engine phy_hs_checker #(
    .GAP  (SAMPLE_GAP),
    .TRIES(MAX_TRIES)
) u_chk (
    .clk  (clk_i),
    .rst  (rst_i),
    .start(start_i),
    .busy (busy_o),
    .done (done_o),
    .err  (err_o),
    .ctrl (phy_ctrl_o)
);

// File: tb/tb_phy_hs_engine.sv
module tb_phy_hs_engine;

    localparam int GAP   = 4;
    localparam int TRIES = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        busy, done, err;
    logic [15:0] rdata;
    logic [31:0] ctrl;
    logic [31:0] stat;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    phy_hs_engine #(.SAMPLE_GAP(GAP), .MAX_TRIES(TRIES)) dut (
        .clk_i(clk), .rst_i(rst), .start_i(start), .wr_i(wr),
        .addr_i(addr), .wdata_i(wdata), .busy_o(busy), .done_o(done),
        .err_o(err), .rdata_o(rdata), .phy_ctrl_o(ctrl), .phy_stat_i(stat)
    );

    // ---------------- PHY responder model ----------------
    localparam int M_NORMAL = 0;
    localparam int M_NOACK  = 1;
    localparam int M_STUCK  = 2;

    int          lat  = 3;
    int          mode = M_NORMAL;
    int          hcnt = 0;
    int          lcnt = 0;
    logic        ackq = 1'b0;
    logic [3:0]  la = '0;
    logic [15:0] ld = '0;
    logic [15:0] mem [16];
    logic        strobe;
    logic        ack;

    assign strobe = |ctrl[19:16];
    assign ack    = (mode == M_NOACK) ? 1'b0 : (mode == M_STUCK) ? 1'b1 : ackq;
    assign stat   = {15'h0, ack, mem[la]};

    always @(posedge clk) begin
        if (rst) begin
            hcnt <= 0;
            lcnt <= 0;
            ackq <= 1'b0;
            la   <= '0;
            ld   <= '0;
            for (int i = 0; i < 16; i++) mem[i] <= 16'(i * 16'h0101);
        end else begin
            if (strobe) begin
                hcnt <= hcnt + 1;
                lcnt <= 0;
                ackq <= (hcnt + 1 >= lat);
            end else begin
                lcnt <= lcnt + 1;
                hcnt <= 0;
                if (lcnt + 1 >= lat) ackq <= 1'b0;
            end
            if (ctrl[16]) la <= ctrl[3:0];
            if (ctrl[17]) ld <= ctrl[15:0];
            if (ctrl[18]) mem[la] <= ld;
        end
    end

    // ---------------- control word trace ----------------
    logic [31:0] tr [32];
    int          tr_n = 0;
    logic [31:0] tr_last = '0;

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (!rst && ctrl != tr_last) begin
            if (tr_n < 32) tr[tr_n] = ctrl;
            tr_n = tr_n + 1;
            tr_last = ctrl;
        end
    end

    always @(negedge clk) begin
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not end (actual %0d cycles, expected < 150000)", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic clear_trace();
        tr_n = 0;
    endtask

    task automatic check_trace(input logic w, input logic [15:0] a, input logic [15:0] d, input string tag);
        logic [31:0] exp [9];
        int n;
        exp[0] = {16'h0, a};
        exp[1] = {16'h1, a};
        exp[2] = {16'h0, a};
        if (w) begin
            exp[3] = {16'h0, d};
            exp[4] = {16'h2, d};
            exp[5] = {16'h0, d};
            exp[6] = 32'h0004_0000;
            exp[7] = {16'h0, d};
            exp[8] = 32'h0;
            n = 9;
        end else begin
            exp[3] = 32'h0008_0000;
            exp[4] = 32'h0;
            n = 5;
        end
        check(tr_n == n, {tag, " word count"}, 32'(tr_n), 32'(n));
        for (int i = 0; i < n && i < tr_n; i++) begin
            check(tr[i] == exp[i], {tag, " word"}, tr[i], exp[i]);
        end
    endtask

    task automatic run_op(input logic w, input logic [15:0] a, input logic [15:0] d, output int busy_cyc);
        @(negedge clk);
        start = 1'b1; wr = w; addr = a; wdata = d;
        @(negedge clk);
        start = 1'b0;
        busy_cyc = 0;
        while (!done) begin
            if (busy) busy_cyc++;
            @(negedge clk);
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check(ctrl == 0,  "R9 ctrl after reset", ctrl, 0);
        check(busy == 0,  "R9 busy after reset", 32'(busy), 0);
        check(done == 0,  "R9 done after reset", 32'(done), 0);
        check(err == 0,   "R9 err after reset", 32'(err), 0);
        check(rdata == 0, "R9 rdata after reset", 32'(rdata), 0);
    endtask

    task automatic t_write_trace();
        int bc;
        mode = M_NORMAL; lat = 3;
        clear_trace();
        run_op(1'b1, 16'h0005, 16'hA5C3, bc);
        check(busy == 0 && err == 0, "R8 busy low/err clear at done", {busy, err}, 0);
        @(negedge clk);
        check(done == 0, "R8 done pulse one cycle", 32'(done), 0);
        check_trace(1'b1, 16'h0005, 16'hA5C3, "R1 R2 R3 write sequence");
    endtask

    task automatic t_read_trace();
        int bc;
        mode = M_NORMAL; lat = 2;
        clear_trace();
        run_op(1'b0, 16'h0005, 16'h0000, bc);
        check(rdata == 16'hA5C3, "R4 read returns written value", 32'(rdata), 32'hA5C3);
        check(err == 0, "R4 read no error", 32'(err), 0);
        check_trace(1'b0, 16'h0005, 16'h0, "R1 R2 R4 read sequence");
    endtask

    task automatic t_patterns();
        int bc;
        logic [15:0] pat [4] = '{16'hFFFF, 16'h0001, 16'h8000, 16'h3C5A};
        mode = M_NORMAL;
        for (int i = 0; i < 4; i++) begin
            lat = 1 + i * 2;
            run_op(1'b1, 16'(8 + i), pat[i], bc);
            check(err == 0, "R3 write pattern ok", 32'(err), 0);
        end
        for (int i = 3; i >= 0; i--) begin
            lat = 5 - i;
            run_op(1'b0, 16'(8 + i), 16'h0, bc);
            check(rdata == pat[i], "R4 readback pattern", 32'(rdata), 32'(pat[i]));
        end
        run_op(1'b0, 16'h0003, 16'h0, bc);
        check(rdata == 16'h0303, "R4 readback untouched register", 32'(rdata), 32'h0303);
    endtask

    task automatic t_timeout();
        int bc;
        mode = M_NOACK;
        run_op(1'b1, 16'h0002, 16'h1234, bc);
        check(err == 1, "R6 no ack gives error", 32'(err), 1);
        check(ctrl == 0, "R6 ctrl zero on error", ctrl, 0);
        check(bc == 1 + (TRIES - 1) * GAP + 1, "R5 busy length of failed wait", 32'(bc), 32'(1 + (TRIES - 1) * GAP + 1));
        @(negedge clk);
        check(done == 0, "R8 done pulse one cycle after error", 32'(done), 0);
        check(rdata == 16'h0303, "R6 rdata kept after error", 32'(rdata), 32'h0303);
        mode = M_NORMAL; lat = 2;
        run_op(1'b0, 16'h0002, 16'h0, bc);
        check(err == 0, "R6 err cleared by next access", 32'(err), 0);
        check(rdata == 16'h0202, "R6 failed write left register", 32'(rdata), 32'h0202);
    endtask

    task automatic t_boundary();
        int bc;
        mode = M_NORMAL;
        lat = (TRIES - 1) * GAP;
        run_op(1'b1, 16'h0006, 16'h6E6E, bc);
        check(err == 0, "R5 ack at last sample succeeds", 32'(err), 0);
        lat = 1;
        run_op(1'b0, 16'h0006, 16'h0, bc);
        check(rdata == 16'h6E6E, "R5 write at last sample landed", 32'(rdata), 32'h6E6E);
        lat = (TRIES - 1) * GAP + 1;
        run_op(1'b1, 16'h0007, 16'h7777, bc);
        check(err == 1, "R5 ack one cycle past last sample fails", 32'(err), 1);
        check(ctrl == 0, "R6 ctrl zero after late ack", ctrl, 0);
        repeat (60) @(negedge clk);
    endtask

    task automatic t_stuck();
        int bc;
        mode = M_STUCK;
        run_op(1'b0, 16'h0004, 16'h0, bc);
        check(err == 1, "R6 ack never falls gives error", 32'(err), 1);
        check(ctrl == 0, "R6 ctrl zero after stuck ack", ctrl, 0);
        mode = M_NORMAL;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_ignore_start();
        int  extra;
        mode = M_NORMAL; lat = 2;
        clear_trace();
        @(negedge clk);
        start = 1'b1; wr = 1'b1; addr = 16'h000B; wdata = 16'hB00B;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1; wr = 1'b0; addr = 16'h0009; wdata = 16'hDEAD;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        check(err == 0, "R7 running write completes", 32'(err), 0);
        extra = 0;
        repeat (20) begin
            @(negedge clk);
            if (busy) extra++;
        end
        check(extra == 0, "R7 no access after ignored start", 32'(extra), 0);
        check_trace(1'b1, 16'h000B, 16'hB00B, "R7 latched request kept");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_trace();
        t_read_trace();
        t_patterns();
        t_timeout();
        t_boundary();
        t_stuck();
        t_ignore_start();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule